// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of page translations. Each slot holds a virtual page number and the physical frame it maps to. It also holds the tag of the address space that owns the slot and a set of flag bits: cacheable, referenced and global. A lookup presents a virtual address. One clock later the block returns whether a usable slot was found, the translated physical address and the slot's flags.

Software or a page-walk engine loads slots through a write port and chooses the slot index itself. A current-address-space register decides which non-global slots may hit. A context switch only reloads that register, so slots that belong to other address spaces stay resident and can hit again after a later switch. Two invalidation commands are provided. One clears every slot. The other clears only the non-global slots that belong to a named address space.

Top module: `tagged_tlb`

## Requirements
- R1: After reset every slot is invalid, the current address-space tag is 0, and rsp_valid, rsp_hit, rsp_multi, rsp_pa and rsp_flags are all 0.
- R2: A lookup hits only on a slot that is valid, whose page number equals VA[31:12], and whose address-space tag equals the current tag or whose global flag is set.
- R3: On a hit, rsp_pa is the slot's frame number in bits [31:12] and the lookup's VA[11:0] in bits [11:0]. rsp_flags carries the slot's flags with bit 0 = cacheable, bit 1 = referenced and bit 2 = global.
- R4: The response appears on the clock edge that follows the lookup. rsp_valid equals the previous cycle's lk_valid. On a miss or an idle cycle, rsp_hit, rsp_multi, rsp_pa and rsp_flags are 0.
- R5: Loading a new current tag invalidates no slot. Slots of a previous address space hit again once that tag is made current again.
- R6: flush_all invalidates every slot, global slots included.
- R7: flush_asid with tag T invalidates only the valid non-global slots whose tag is T. Global slots and slots of other tags keep hitting.
- R8: When more than one slot hits, rsp_multi is 1 and the data returned comes from the lowest-index hitting slot.
- R9: A write, flush or tag change in the same cycle as a lookup is not seen by that lookup. It is seen by the next lookup.
- R10: A write in the same cycle as a flush command takes effect after the flush, so the written slot stays as written.
- R11: A write with wr_valid = 0 invalidates the addressed slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | 4 | Slot index to write |
| wr_valid | input | 1 | Valid bit written to the slot |
| wr_vpn | input | 20 | Virtual page number written |
| wr_pfn | input | 20 | Physical frame number written |
| wr_asid | input | 8 | Address-space tag written |
| wr_flags | input | 3 | Flags written (bit0 cacheable, bit1 referenced, bit2 global) |
| asid_load | input | 1 | Load the current address-space tag |
| asid_new | input | 8 | New current address-space tag |
| flush_all | input | 1 | Invalidate every slot |
| flush_asid | input | 1 | Invalidate non-global slots of one tag |
| flush_asid_val | input | 8 | Tag targeted by flush_asid |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup found a usable slot |
| rsp_multi | output | 1 | More than one slot matched |
| rsp_pa | output | 32 | Translated physical address |
| rsp_flags | output | 3 | Flags of the selected slot |

## Verification
The bench uses the default parameters: 16 slots, an 8-bit tag, 4 KiB pages and 32-bit addresses. With these values it can write the highest slot index (15) and use the extreme tag value 0xFF against a global slot. It can also place duplicate page numbers in slots 7 and 9, which tests the lowest-index choice and the multi-hit flag. The narrow 8-bit tag lets the bench cycle through several address spaces and return to the first one, which shows that earlier slots survive a switch.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   localparam int FLAG_W   = 3;
   localparam int FLG_CACH = 0;
   localparam int FLG_REFD = 1;
   localparam int FLG_GLOB = 2;

   typedef struct packed {
      logic glob;
      logic refd;
      logic cach;
   } tlb_flags_t;
endpackage

// File: rtl/tlb_store.sv
module tlb_store
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20,
   parameter int ASID_W  = 8,
   parameter int IDX_W   = $clog2(ENTRIES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [IDX_W-1:0]          wr_idx,
   input  logic                      wr_valid,
   input  logic [VPN_W-1:0]          wr_vpn,
   input  logic [PFN_W-1:0]          wr_pfn,
   input  logic [ASID_W-1:0]         wr_asid,
   input  logic [FLAG_W-1:0]         wr_flags,
   input  logic                      flush_all,
   input  logic                      flush_asid,
   input  logic [ASID_W-1:0]         flush_asid_val,
   output logic [ENTRIES-1:0]        ent_valid,
   output logic [ENTRIES*VPN_W-1:0]  ent_vpn,
   output logic [ENTRIES*PFN_W-1:0]  ent_pfn,
   output logic [ENTRIES*ASID_W-1:0] ent_asid,
   output logic [ENTRIES*FLAG_W-1:0] ent_flags
);
   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      tlb_flags_t           f_q;
      logic                 v_q;
      logic [VPN_W-1:0]     vpn_q;
      logic [PFN_W-1:0]     pfn_q;
      logic [ASID_W-1:0]    asid_q;
      logic                 sel;
      logic                 kill;

      assign sel  = wr_en && (wr_idx == IDX_W'(i));
      assign kill = flush_all ||
                    (flush_asid && !f_q.glob && (asid_q == flush_asid_val));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q    <= 1'b0;
            vpn_q  <= '0;
            pfn_q  <= '0;
            asid_q <= '0;
            f_q    <= '0;
         end else begin
            if (kill) v_q <= 1'b0;
            if (sel) begin
               v_q    <= wr_valid;
               vpn_q  <= wr_vpn;
               pfn_q  <= wr_pfn;
               asid_q <= wr_asid;
               f_q    <= tlb_flags_t'(wr_flags);
            end
         end
      end

      assign ent_valid[i]                 = v_q;
      assign ent_vpn[i*VPN_W +: VPN_W]    = vpn_q;
      assign ent_pfn[i*PFN_W +: PFN_W]    = pfn_q;
      assign ent_asid[i*ASID_W +: ASID_W] = asid_q;
      assign ent_flags[i*FLAG_W +: FLAG_W] = f_q;
   end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int ASID_W  = 8
) (
   input  logic [ENTRIES-1:0]        ent_valid,
   input  logic [ENTRIES*VPN_W-1:0]  ent_vpn,
   input  logic [ENTRIES*ASID_W-1:0] ent_asid,
   input  logic [ENTRIES*FLAG_W-1:0] ent_flags,
   input  logic [VPN_W-1:0]          look_vpn,
   input  logic [ASID_W-1:0]         cur_asid,
   output logic [ENTRIES-1:0]        match
);
   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      logic page_eq;
      logic space_ok;
      tlb_flags_t f;
      assign f        = tlb_flags_t'(ent_flags[i*FLAG_W +: FLAG_W]);
      assign page_eq  = (ent_vpn[i*VPN_W +: VPN_W] == look_vpn);
      assign space_ok = f.glob || (ent_asid[i*ASID_W +: ASID_W] == cur_asid);
      assign match[i] = ent_valid[i] && page_eq && space_ok;
   end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick
   import tlb_pkg::*;
#(
   parameter int ENTRIES    = 16,
   parameter int PFN_W      = 20,
   parameter bit AND_OR_SEL = 1'b1,
   parameter int IDX_W      = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0]        match,
   input  logic [ENTRIES*PFN_W-1:0]  ent_pfn,
   input  logic [ENTRIES*FLAG_W-1:0] ent_flags,
   output logic                      hit,
   output logic                      multi,
   output logic [PFN_W-1:0]          pfn,
   output logic [FLAG_W-1:0]         flags
);
   logic [ENTRIES-1:0] first_oh;

   assign first_oh = match & (~match + ENTRIES'(1));
   assign hit      = |match;
   assign multi    = |(match & ~first_oh);

   if (AND_OR_SEL) begin : g_andor
      always_comb begin
         pfn   = '0;
         flags = '0;
         for (int i = 0; i < ENTRIES; i++) begin
            pfn   = pfn   | (ent_pfn[i*PFN_W +: PFN_W]    & {PFN_W{first_oh[i]}});
            flags = flags | (ent_flags[i*FLAG_W +: FLAG_W] & {FLAG_W{first_oh[i]}});
         end
      end
   end else begin : g_index
      logic [IDX_W-1:0] sel_idx;
      always_comb begin
         sel_idx = '0;
         for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (first_oh[i]) sel_idx = IDX_W'(i);
         end
      end
      assign pfn   = ent_pfn[sel_idx*PFN_W +: PFN_W];
      assign flags = ent_flags[sel_idx*FLAG_W +: FLAG_W];
   end
endmodule

// File: rtl/tagged_tlb.sv
module tagged_tlb
   import tlb_pkg::*;
#(
   parameter int VA_W       = 32,
   parameter int PA_W       = 32,
   parameter int PAGE_BITS  = 12,
   parameter int ENTRIES    = 16,
   parameter int ASID_W     = 8,
   parameter bit AND_OR_SEL = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         lk_valid,
   input  logic [VA_W-1:0]              lk_va,
   input  logic                         wr_en,
   input  logic [$clog2(ENTRIES)-1:0]   wr_idx,
   input  logic                         wr_valid,
   input  logic [VA_W-PAGE_BITS-1:0]    wr_vpn,
   input  logic [PA_W-PAGE_BITS-1:0]    wr_pfn,
   input  logic [ASID_W-1:0]            wr_asid,
   input  logic [2:0]                   wr_flags,
   input  logic                         asid_load,
   input  logic [ASID_W-1:0]            asid_new,
   input  logic                         flush_all,
   input  logic                         flush_asid,
   input  logic [ASID_W-1:0]            flush_asid_val,
   output logic                         rsp_valid,
   output logic                         rsp_hit,
   output logic                         rsp_multi,
   output logic [PA_W-1:0]              rsp_pa,
   output logic [2:0]                   rsp_flags
);
   localparam int VPN_W = VA_W - PAGE_BITS;
   localparam int PFN_W = PA_W - PAGE_BITS;
   localparam int IDX_W = $clog2(ENTRIES);

   if (ENTRIES < 2)               begin : g_bad_depth $error("ENTRIES must be at least 2"); end
   if (PAGE_BITS >= VA_W)         begin : g_bad_va    $error("PAGE_BITS must be below VA_W"); end
   if (PAGE_BITS >= PA_W)         begin : g_bad_pa    $error("PAGE_BITS must be below PA_W"); end
   if (ASID_W < 1)                begin : g_bad_asid  $error("ASID_W must be positive"); end
   if (FLAG_W != 3)               begin : g_bad_flag  $error("flag layout must be 3 bits"); end

   logic [ASID_W-1:0]         cur_asid_q;
   logic [ENTRIES-1:0]        ent_valid;
   logic [ENTRIES*VPN_W-1:0]  ent_vpn;
   logic [ENTRIES*PFN_W-1:0]  ent_pfn;
   logic [ENTRIES*ASID_W-1:0] ent_asid;
   logic [ENTRIES*FLAG_W-1:0] ent_flags;
   logic [ENTRIES-1:0]        match;
   logic                      c_hit;
   logic                      c_multi;
   logic [PFN_W-1:0]          c_pfn;
   logic [FLAG_W-1:0]         c_flags;
   logic                      take;

   always_ff @(posedge clk) begin
      if (!rst_n)         cur_asid_q <= '0;
      else if (asid_load) cur_asid_q <= asid_new;
   end

   tlb_store #(
      .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
      .wr_vpn(wr_vpn), .wr_pfn(wr_pfn), .wr_asid(wr_asid), .wr_flags(wr_flags),
      .flush_all(flush_all), .flush_asid(flush_asid), .flush_asid_val(flush_asid_val),
      .ent_valid(ent_valid), .ent_vpn(ent_vpn), .ent_pfn(ent_pfn),
      .ent_asid(ent_asid), .ent_flags(ent_flags)
   );

   tlb_cam #(
      .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)
   ) u_cam (
      .ent_valid(ent_valid), .ent_vpn(ent_vpn), .ent_asid(ent_asid),
      .ent_flags(ent_flags), .look_vpn(lk_va[VA_W-1:PAGE_BITS]),
      .cur_asid(cur_asid_q), .match(match)
   );

   tlb_pick #(
      .ENTRIES(ENTRIES), .PFN_W(PFN_W), .AND_OR_SEL(AND_OR_SEL), .IDX_W(IDX_W)
   ) u_pick (
      .match(match), .ent_pfn(ent_pfn), .ent_flags(ent_flags),
      .hit(c_hit), .multi(c_multi), .pfn(c_pfn), .flags(c_flags)
   );

   assign take = lk_valid && c_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_multi <= 1'b0;
         rsp_pa    <= '0;
         rsp_flags <= '0;
      end else begin
         rsp_valid <= lk_valid;
         rsp_hit   <= take;
         rsp_multi <= take && c_multi;
         rsp_pa    <= take ? {c_pfn, lk_va[PAGE_BITS-1:0]} : '0;
         rsp_flags <= take ? c_flags : '0;
      end
   end
endmodule

// File: rtl/tagged_tlb_chk.sv
module tagged_tlb_chk #(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int PAGE_BITS = 12
) (
   input logic            clk,
   input logic            rst_n,
   input logic            lk_valid,
   input logic [VA_W-1:0] lk_va,
   input logic            wr_en,
   input logic            flush_all,
   input logic            rsp_valid,
   input logic            rsp_hit,
   input logic            rsp_multi,
   input logic [PA_W-1:0] rsp_pa,
   input logic [2:0]      rsp_flags
);
   logic armed;
   logic fl_q;
   logic fl_look_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed     <= 1'b0;
         fl_q      <= 1'b0;
         fl_look_q <= 1'b0;
      end else begin
         armed     <= 1'b1;
         fl_q      <= flush_all && !wr_en;
         fl_look_q <= fl_q && lk_valid;
      end
   end

   assert_rsp_follows_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (rsp_valid == $past(lk_valid)));

   assert_miss_is_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_hit |-> (rsp_pa == '0 && rsp_flags == '0 && !rsp_multi));

   assert_hit_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_valid);

   assert_offset_passes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && rsp_hit) |-> (rsp_pa[PAGE_BITS-1:0] == $past(lk_va[PAGE_BITS-1:0])));

   assert_multi_implies_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_multi |-> rsp_hit);

   assert_flush_all_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fl_look_q |-> !rsp_hit);
endmodule

bind tagged_tlb tagged_tlb_chk #(
   .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va),
   .wr_en(wr_en), .flush_all(flush_all),
   .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_multi(rsp_multi),
   .rsp_pa(rsp_pa), .rsp_flags(rsp_flags)
);

// File: tb/tagged_tlb_bench.sv
module tagged_tlb_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        lk_valid;
   logic [31:0] lk_va;
   logic        wr_en;
   logic [3:0]  wr_idx;
   logic        wr_valid;
   logic [19:0] wr_vpn;
   logic [19:0] wr_pfn;
   logic [7:0]  wr_asid;
   logic [2:0]  wr_flags;
   logic        asid_load;
   logic [7:0]  asid_new;
   logic        flush_all;
   logic        flush_asid;
   logic [7:0]  flush_asid_val;
   logic        rsp_valid;
   logic        rsp_hit;
   logic        rsp_multi;
   logic [31:0] rsp_pa;
   logic [2:0]  rsp_flags;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   tagged_tlb u_tagged_tlb (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_vpn(wr_vpn),
      .wr_pfn(wr_pfn), .wr_asid(wr_asid), .wr_flags(wr_flags),
      .asid_load(asid_load), .asid_new(asid_new), .flush_all(flush_all),
      .flush_asid(flush_asid), .flush_asid_val(flush_asid_val),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_multi(rsp_multi),
      .rsp_pa(rsp_pa), .rsp_flags(rsp_flags)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic check_rsp(input bit eh, input logic [31:0] epa, input logic [2:0] ef,
                            input bit em, input string req);
      chk(req, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
      chk(req, "rsp_hit",   {31'd0, rsp_hit},   {31'd0, eh});
      chk(req, "rsp_pa",    rsp_pa,             epa);
      chk(req, "rsp_flags", {29'd0, rsp_flags}, {29'd0, ef});
      chk(req, "rsp_multi", {31'd0, rsp_multi}, {31'd0, em});
   endtask

   task automatic look(input logic [31:0] va, input bit eh, input logic [31:0] epa,
                       input logic [2:0] ef, input bit em, input string req);
      @(negedge clk);
      lk_valid = 1'b1; lk_va = va;
      @(negedge clk);
      lk_valid = 1'b0;
      check_rsp(eh, epa, ef, em, req);
   endtask

   task automatic put_wr(input logic [3:0] idx, input bit v, input logic [19:0] vpn,
                         input logic [19:0] pfn, input logic [7:0] asid, input logic [2:0] fl);
      wr_en = 1'b1; wr_idx = idx; wr_valid = v; wr_vpn = vpn;
      wr_pfn = pfn; wr_asid = asid; wr_flags = fl;
   endtask

   task automatic write_slot(input logic [3:0] idx, input bit v, input logic [19:0] vpn,
                             input logic [19:0] pfn, input logic [7:0] asid, input logic [2:0] fl);
      @(negedge clk);
      put_wr(idx, v, vpn, pfn, asid, fl);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_asid(input logic [7:0] a);
      @(negedge clk);
      asid_load = 1'b1; asid_new = a;
      @(negedge clk);
      asid_load = 1'b0;
   endtask

   task automatic kill_asid(input logic [7:0] a);
      @(negedge clk);
      flush_asid = 1'b1; flush_asid_val = a;
      @(negedge clk);
      flush_asid = 1'b0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R1", "rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
      chk("R1", "rsp_hit after reset",   {31'd0, rsp_hit},   32'd0);
      chk("R1", "rsp_pa after reset",    rsp_pa,             32'd0);
      look(32'h0000_0000, 1'b0, 32'd0, 3'd0, 1'b0, "R1");
      look(32'h1234_5678, 1'b0, 32'd0, 3'd0, 1'b0, "R1");
   endtask

   task automatic t_basic;
      write_slot(4'd3, 1'b1, 20'h12345, 20'hABCDE, 8'h00, 3'b011);
      look(32'h1234_5678, 1'b1, 32'hABCD_E678, 3'b011, 1'b0, "R2 R3 R1");
      look(32'h1234_6678, 1'b0, 32'd0, 3'd0, 1'b0, "R2");
      look(32'h1234_5FFF, 1'b1, 32'hABCD_EFFF, 3'b011, 1'b0, "R3");
   endtask

   task automatic t_spaces;
      set_asid(8'h05);
      look(32'h1234_5678, 1'b0, 32'd0, 3'd0, 1'b0, "R2");
      write_slot(4'd4, 1'b1, 20'h12345, 20'h11111, 8'h05, 3'b001);
      look(32'h1234_5ABC, 1'b1, 32'h1111_1ABC, 3'b001, 1'b0, "R2");
      write_slot(4'd15, 1'b1, 20'h0000F, 20'h0F0F0, 8'h77, 3'b100);
      look(32'h0000_F123, 1'b1, 32'h0F0F_0123, 3'b100, 1'b0, "R2");
      set_asid(8'hFF);
      look(32'h0000_F123, 1'b1, 32'h0F0F_0123, 3'b100, 1'b0, "R2");
      set_asid(8'h00);
      look(32'h1234_5678, 1'b1, 32'hABCD_E678, 3'b011, 1'b0, "R5");
      set_asid(8'h05);
      look(32'h1234_5678, 1'b1, 32'h1111_1678, 3'b001, 1'b0, "R5");
      set_asid(8'h00);
   endtask

   task automatic t_multi;
      write_slot(4'd7, 1'b1, 20'h55555, 20'h00007, 8'h00, 3'b001);
      write_slot(4'd9, 1'b1, 20'h55555, 20'h00009, 8'h00, 3'b010);
      look(32'h5555_5000, 1'b1, 32'h0000_7000, 3'b001, 1'b1, "R8");
      write_slot(4'd7, 1'b0, 20'h55555, 20'h00007, 8'h00, 3'b001);
      look(32'h5555_5000, 1'b1, 32'h0000_9000, 3'b010, 1'b0, "R11");
   endtask

   task automatic t_flush_tag;
      kill_asid(8'h05);
      set_asid(8'h05);
      look(32'h1234_5678, 1'b0, 32'd0, 3'd0, 1'b0, "R7");
      look(32'h0000_F123, 1'b1, 32'h0F0F_0123, 3'b100, 1'b0, "R7");
      set_asid(8'h00);
      look(32'h1234_5678, 1'b1, 32'hABCD_E678, 3'b011, 1'b0, "R7");
      kill_asid(8'h77);
      look(32'h0000_F123, 1'b1, 32'h0F0F_0123, 3'b100, 1'b0, "R7");
   endtask

   task automatic t_same_cycle;
      @(negedge clk);
      put_wr(4'd10, 1'b1, 20'h2AAAA, 20'h0BEEF, 8'h00, 3'b001);
      lk_valid = 1'b1; lk_va = 32'h2AAA_A010;
      @(negedge clk);
      wr_en = 1'b0; lk_valid = 1'b0;
      check_rsp(1'b0, 32'd0, 3'd0, 1'b0, "R9");
      look(32'h2AAA_A010, 1'b1, 32'h0BEE_F010, 3'b001, 1'b0, "R9");
      @(negedge clk);
      asid_load = 1'b1; asid_new = 8'h05;
      lk_valid = 1'b1; lk_va = 32'h2AAA_A010;
      @(negedge clk);
      asid_load = 1'b0; lk_valid = 1'b0;
      check_rsp(1'b1, 32'h0BEE_F010, 3'b001, 1'b0, "R9");
      look(32'h2AAA_A010, 1'b0, 32'd0, 3'd0, 1'b0, "R9");
      set_asid(8'h00);
   endtask

   task automatic t_flush_all;
      @(negedge clk);
      put_wr(4'd2, 1'b1, 20'h03333, 20'h04444, 8'h00, 3'b000);
      flush_all = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; flush_all = 1'b0;
      look(32'h0333_3001, 1'b1, 32'h0444_4001, 3'b000, 1'b0, "R10");
      look(32'h0000_F123, 1'b0, 32'd0, 3'd0, 1'b0, "R6");
      look(32'h2AAA_A010, 1'b0, 32'd0, 3'd0, 1'b0, "R6");
      look(32'h5555_5000, 1'b0, 32'd0, 3'd0, 1'b0, "R6");
      @(negedge clk);
      flush_all = 1'b1;
      @(negedge clk);
      flush_all = 1'b0;
      look(32'h0333_3001, 1'b0, 32'd0, 3'd0, 1'b0, "R6");
   endtask

   initial begin
      rst_n = 1'b0; lk_valid = 1'b0; lk_va = '0; wr_en = 1'b0; wr_idx = '0;
      wr_valid = 1'b0; wr_vpn = '0; wr_pfn = '0; wr_asid = '0; wr_flags = '0;
      asid_load = 1'b0; asid_new = '0; flush_all = 1'b0; flush_asid = 1'b0;
      flush_asid_val = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_spaces();
      t_multi();
      t_flush_tag();
      t_same_cycle();
      t_flush_all();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule